// File: doc/BRIEF.md
# LFSR Terminal-Count Timer

This block measures a fixed number of enabled clock cycles and reports only the moment that number is reached. A binary incrementer is not used. The count state is a maximal-length linear feedback shift register, whose next state needs a single shift plus a small XOR of a few tap bits. The carry chain of an adder is therefore absent from the critical path.

The state visits an arbitrary but fixed order of non-zero codes. The code the register holds after the desired number of steps is worked out at elaboration time from the seed. At run time a single equality compare against that constant marks the terminal cycle.

A start strobe loads the seed and arms the timer. Each cycle with enable high then advances it by one step. A registered pulse of one cycle reports the terminal count. The mode input chooses what happens next:
- The timer reloads and keeps timing periods of the same length.
- Or it goes idle until the next start.

Top module: `lfsr_tc_timer`

## Requirements
- R1: After synchronous reset the pulse output is low and the timer is idle. While idle and without a start, no pulse is produced whatever the enable does.
- R2: With COUNT configured, the pulse goes high for exactly one cycle. It appears in the cycle that follows the COUNT-th rising edge with enable high after the edge at which start was sampled high. The start edge itself is not counted.
- R3: An edge with enable low and start low neither advances the count nor produces a pulse, so each disabled cycle delays the pulse by one cycle.
- R4: With wrap_mode high at the terminal edge, the timer reloads its seed in that same edge. It then pulses again after every further COUNT enabled edges.
- R5: With wrap_mode low at the terminal edge, the timer stops after its pulse. It produces no further pulse until the next start.
- R6: A start strobe restarts the count from zero even while a count is in progress. Start takes effect whether enable is high or low.
- R7: The boundaries work: COUNT=1 gives a pulse after every enabled edge in wrap mode. COUNT=2^WIDTH−1 gives the full sequence length, and the register never holds the all-zero code while running.
- R8: Reset in the middle of a count clears the pulse and the count. No pulse follows until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; each edge with en high advances one step |
| start | input | 1 | Loads the seed and arms the timer; restarts a running count |
| wrap_mode | input | 1 | 1: reload and keep timing at terminal; 0: stop at terminal |
| tc_pulse | output | 1 | Registered one-cycle terminal-count pulse |

## Verification
The hardest case to reach from the ports is the longest configuration. A pulse at exactly 2^WIDTH−1 enabled cycles only happens if the compare constant was derived correctly and the feedback really gives the full period. The stimulus therefore runs instances with COUNT=1, a short count, the maximum count, and a narrower width with a different seed side by side from shared inputs. A cycle-accurate binary reference counter in the bench is compared against each instance on every cycle, while enable is held high and also while it follows an irregular gating pattern. Restarts and resets are issued mid-count, so a stale state would show up as a pulse at the wrong time.

// File: rtl/lfsr_tc_pkg.sv
package lfsr_tc_pkg;

  localparam int MAXW = 32;

  // Feedback tap mask for a maximal-length sequence, bit (t-1) set for tap t.
  function automatic logic [MAXW-1:0] tap_mask(input int w);
    logic [MAXW-1:0] m;
    case (w)
      3:  m = 32'h0000_0006;
      4:  m = 32'h0000_000C;
      5:  m = 32'h0000_0014;
      6:  m = 32'h0000_0030;
      7:  m = 32'h0000_0060;
      8:  m = 32'h0000_00B8;
      9:  m = 32'h0000_0110;
      10: m = 32'h0000_0240;
      11: m = 32'h0000_0500;
      12: m = 32'h0000_0829;
      13: m = 32'h0000_100D;
      14: m = 32'h0000_2015;
      15: m = 32'h0000_6000;
      16: m = 32'h0000_D008;
      default: m = 32'h0000_0060;
    endcase
    return m;
  endfunction

  // One step: shift toward the MSB, parity of the tapped bits enters at bit 0.
  function automatic logic [MAXW-1:0] lfsr_adv(input logic [MAXW-1:0] s, input int w);
    logic [MAXW-1:0] keep;
    logic [MAXW-1:0] r;
    keep = (w >= MAXW) ? '1 : ((MAXW'(1) << w) - MAXW'(1));
    r    = ((s << 1) & keep) | MAXW'(^(s & tap_mask(w)));
    return r;
  endfunction

  // Code held after (count-1) steps from the seed: the terminal compare value.
  function automatic logic [MAXW-1:0] term_code(input logic [MAXW-1:0] seed,
                                                 input int w, input int count);
    logic [MAXW-1:0] s;
    s = seed;
    for (int i = 1; i < count; i++) s = lfsr_adv(s, w);
    return s;
  endfunction

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  import lfsr_tc_pkg::*;

  localparam logic [WIDTH-1:0] TAPS = WIDTH'(tap_mask(WIDTH));

  logic fb;

  always_comb begin
    fb  = ^(cur & TAPS);
    nxt = {cur[WIDTH-2:0], fb};
  end

endmodule

// File: rtl/tc_match.sv
module tc_match #(
  parameter int              WIDTH = 7,
  parameter logic [WIDTH-1:0] TERM = '0
) (
  input  logic [WIDTH-1:0] cur,
  output logic             hit
);

  logic [WIDTH-1:0] diff;

  always_comb begin
    diff = cur ^ TERM;
    hit  = ~|diff;
  end

endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl #(
  parameter int               WIDTH = 7,
  parameter int               COUNT = 100,
  parameter logic [WIDTH-1:0] SEED  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             wrap_mode,
  input  logic [WIDTH-1:0] nxt_state,
  input  logic             at_term,
  output logic [WIDTH-1:0] state,
  output logic             running,
  output logic             tc_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEED;
      running  <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      if (start) begin
        state   <= SEED;
        running <= 1'b1;
      end else if (running && en) begin
        if (at_term) begin
          tc_pulse <= 1'b1;
          state    <= SEED;
          running  <= wrap_mode;
        end else begin
          state <= nxt_state;
        end
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> !tc_pulse);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && (COUNT > 1)) |=> !tc_pulse);

  a_r3_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (running && !en && !start) |=> ($stable(state) && !tc_pulse));

  a_r5_stop_after_tc: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && !running) |=> !tc_pulse);

  a_r6_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (running && (state == SEED) && !tc_pulse));

  a_r7_never_zero: assert property (@(posedge clk) disable iff (rst)
    running |-> (state != '0));

endmodule

// File: rtl/lfsr_tc_timer.sv
module lfsr_tc_timer #(
  parameter int               WIDTH = 7,
  parameter int               COUNT = 100,
  parameter logic [WIDTH-1:0] SEED  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic wrap_mode,
  output logic tc_pulse
);
  import lfsr_tc_pkg::*;

  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_code(MAXW'(SEED), WIDTH, COUNT));

  initial begin
    a_r7_cfg: assert (WIDTH >= 3 && WIDTH <= 16 && COUNT >= 1 &&
                      COUNT <= (1 << WIDTH) - 1 && SEED != '0);
  end

  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] nxt_state;
  logic             at_term;
  logic             running;

  lfsr_next #(.WIDTH(WIDTH)) u_next (
    .cur (state),
    .nxt (nxt_state)
  );

  tc_match #(.WIDTH(WIDTH), .TERM(TERM)) u_match (
    .cur (state),
    .hit (at_term)
  );

  tc_ctrl #(.WIDTH(WIDTH), .COUNT(COUNT), .SEED(SEED)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .start     (start),
    .wrap_mode (wrap_mode),
    .nxt_state (nxt_state),
    .at_term   (at_term),
    .state     (state),
    .running   (running),
    .tc_pulse  (tc_pulse)
  );

endmodule

// File: tb/test_lfsr_tc_timer.sv
module test_lfsr_tc_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int CNTS [NI] = '{5, 1, 127, 11};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic start = 1'b0;
  logic wrap_mode = 1'b0;
  logic [NI-1:0] tc;

  int checks = 0;
  int failures = 0;
  int pulses [NI];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_tc_timer #(.WIDTH(7), .COUNT(5),   .SEED(7'h01)) i_lfsr_tc_timer (
    .clk(clk), .rst(rst), .en(en), .start(start), .wrap_mode(wrap_mode), .tc_pulse(tc[0]));
  lfsr_tc_timer #(.WIDTH(7), .COUNT(1),   .SEED(7'h2A)) i_lfsr_tc_timer_c1 (
    .clk(clk), .rst(rst), .en(en), .start(start), .wrap_mode(wrap_mode), .tc_pulse(tc[1]));
  lfsr_tc_timer #(.WIDTH(7), .COUNT(127), .SEED(7'h01)) i_lfsr_tc_timer_max (
    .clk(clk), .rst(rst), .en(en), .start(start), .wrap_mode(wrap_mode), .tc_pulse(tc[2]));
  lfsr_tc_timer #(.WIDTH(4), .COUNT(11),  .SEED(4'h9))  i_lfsr_tc_timer_w4 (
    .clk(clk), .rst(rst), .en(en), .start(start), .wrap_mode(wrap_mode), .tc_pulse(tc[3]));

  // Binary reference counters, one per instance.
  logic exp_p [NI];
  int   rcnt  [NI];
  bit   rrun  [NI];

  always @(posedge clk) begin
    for (int i = 0; i < NI; i++) begin
      if (rst) begin
        exp_p[i] <= 1'b0; rcnt[i] <= 0; rrun[i] <= 1'b0;
      end else if (start) begin
        exp_p[i] <= 1'b0; rcnt[i] <= 0; rrun[i] <= 1'b1;
      end else if (en && rrun[i]) begin
        if (rcnt[i] + 1 == CNTS[i]) begin
          exp_p[i] <= 1'b1; rcnt[i] <= 0; rrun[i] <= wrap_mode;
        end else begin
          exp_p[i] <= 1'b0; rcnt[i] <= rcnt[i] + 1;
        end
      end else begin
        exp_p[i] <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock; outputs compared with the reference at the falling edge.
  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check($sformatf("%s inst%0d pulse", tag, i), int'(tc[i]), int'(exp_p[i]));
      if (tc[i]) pulses[i]++;
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NI; i++) pulses[i] = 0;
  endtask

  task automatic do_start(input string tag, input logic en_val);
    start = 1'b1; en = en_val;
    tick(tag);
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    tick("R1"); tick("R1");
    rst = 1'b0;
    clear_counts();
    for (int k = 0; k < 12; k++) tick("R1");
    for (int i = 0; i < NI; i++) check($sformatf("R1 idle pulses inst%0d", i), pulses[i], 0);
  endtask

  task automatic t_stop_mode();
    wrap_mode = 1'b0;
    do_start("R2", 1'b1);
    en = 1'b1;
    clear_counts();
    for (int k = 1; k <= 140; k++) begin
      tick("R2");
      if (k == 5) check("R2 inst0 pulse at 5th enabled edge", int'(tc[0]), 1);
      if (k == 4) check("R2 inst0 quiet at 4th edge", int'(tc[0]), 0);
    end
    for (int i = 0; i < NI; i++) check($sformatf("R5 stop pulses inst%0d", i), pulses[i], 1);
  endtask

  task automatic t_wrap_mode();
    wrap_mode = 1'b1;
    do_start("R4", 1'b1);
    en = 1'b1;
    clear_counts();
    for (int k = 1; k <= 260; k++) tick("R4");
    check("R4 wrap pulses inst0", pulses[0], 52);
    check("R7 count1 pulses every edge", pulses[1], 260);
    check("R7 max count pulses", pulses[2], 2);
    check("R4 wrap pulses width4", pulses[3], 23);
  endtask

  task automatic t_gating();
    wrap_mode = 1'b0;
    do_start("R3", 1'b0);
    clear_counts();
    for (int k = 1; k <= 260; k++) begin
      en = (k % 3) != 0;
      tick("R3");
    end
    en = 1'b1;
    for (int i = 0; i < NI; i++) check($sformatf("R3 gated pulses inst%0d", i), pulses[i], 1);
    // Idle with enable toggling: no pulse.
    clear_counts();
    for (int k = 0; k < 6; k++) begin en = k[0]; tick("R1"); end
    for (int i = 0; i < NI; i++) check($sformatf("R1 post-stop pulses inst%0d", i), pulses[i], 0);
  endtask

  task automatic t_restart();
    wrap_mode = 1'b0;
    do_start("R6", 1'b1);
    en = 1'b1;
    for (int k = 0; k < 3; k++) tick("R6");
    do_start("R6", 1'b0);
    en = 1'b1;
    clear_counts();
    for (int k = 1; k <= 4; k++) tick("R6");
    check("R6 restart delays inst0", pulses[0], 0);
    tick("R6");
    check("R6 inst0 pulse 5 edges after restart", int'(tc[0]), 1);
  endtask

  task automatic t_mid_reset();
    wrap_mode = 1'b1;
    do_start("R8", 1'b1);
    en = 1'b1;
    for (int k = 0; k < 3; k++) tick("R8");
    rst = 1'b1;
    tick("R8");
    check("R8 pulse cleared by reset inst1", int'(tc[1]), 0);
    rst = 1'b0;
    clear_counts();
    for (int k = 0; k < 15; k++) tick("R8");
    for (int i = 0; i < NI; i++) check($sformatf("R8 no pulse after reset inst%0d", i), pulses[i], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_counts();
    @(negedge clk);
    t_reset();
    t_stop_mode();
    t_wrap_mode();
    t_gating();
    t_restart();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule